// File: doc/BRIEF.md
# Hysteresis Line Slicer with Transition-Aligned Bit Recovery

This block turns a stream of 12-bit converter codes into a recovered serial bit stream. Each code that arrives with a sample strobe is scaled to millivolts and offset by a fixed midpoint. A two-state line-level machine with a hysteresis band turns this signed difference into a clean line level.

A run-length counter and a commit threshold recover the bit timing from the line edges. Each time the line level flips, the sampling phase is moved to half a bit period after the edge. From there it steps by whole bit periods, and one bit is emitted each time the run length reaches the threshold. Recovered bits leave one at a time, in arrival order, with a single-cycle valid pulse, for a downstream 8b/10b symbol decoder.

The hysteresis width and the bit period are run-time registers. A synchronous clear puts both back to their defaults.

The line-level machine has two states. In `LINE_LOW`, the RISE transition to `LINE_HIGH` is taken on a strobed sample whose difference is above +width/2. In `LINE_HIGH`, the FALL transition to `LINE_LOW` is taken on a strobed sample whose difference is below −width/2. Every other case keeps the current state.

Top module: `line_bit_recover`

## Requirements
- R1: After asynchronous reset, the line level is `LINE_LOW` (`dbg_level` = 0), `dbg_len` = 0, `dbg_commit` = 0, and `bit_vld` = 0.
- R2: A strobed code c gives the difference d = ((c × 13300) >> 12) − 5500, in millivolts. If d > width/2 the line level becomes 1. If d < −width/2 it becomes 0. Here width/2 is the width register shifted right by one.
- R3: When −width/2 ≤ d ≤ width/2, including both exact edges, the line level keeps its previous value.
- R4: On a strobed sample that changes the line level, that sample's emit decision uses a run length of 0 and a threshold of period >> 1. After that sample, `dbg_len` reads 1.
- R5: On a strobed sample, `bit_vld` pulses in the same cycle when the run length is at or above the threshold. `bit_out` carries the updated line level, and the threshold then grows by one period.
- R6: Each strobed sample adds one to `dbg_len`. The counter saturates at 2^16−1. A cycle without a strobe leaves `dbg_len`, `dbg_commit` and `dbg_level` unchanged.
- R7: `dbg_commit` saturates at 2^16−1 and never wraps to a smaller value.
- R8: A register write affects samples from the next cycle onward. At reset the width is 6000 and the period is 10. `clr` restores both defaults and takes priority over a write in the same cycle.
- R9: `bit_vld` is never high in a cycle without `smp_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous restore of the width and period defaults |
| wr_band | input | 1 | Write strobe for the hysteresis width |
| wr_band_val | input | 16 | New hysteresis width in mV |
| wr_period | input | 1 | Write strobe for the bit period |
| wr_period_val | input | 16 | New bit period in samples |
| smp_stb | input | 1 | Sample strobe |
| smp_code | input | 12 | Converter code |
| bit_vld | output | 1 | Recovered-bit pulse, same cycle as the strobe |
| bit_out | output | 1 | Updated line level, the bit value when `bit_vld` is high |
| dbg_level | output | 1 | Registered line level |
| dbg_len | output | 16 | Run-length counter |
| dbg_commit | output | 16 | Commit threshold |

## Verification
The assertions assume that `smp_code` and `smp_stb` are known whenever reset is released, and that the period register is never zero. With a zero period the threshold would stop advancing and bits would be emitted on every sample.

The bench only writes periods between 3 and 40000 and only changes inputs on the falling clock edge. Within that, it sweeps every code upward and downward, feeds square runs of many lengths for several periods, and holds the line for more than 2^16 samples to drive both counters into saturation.

// File: rtl/slc_pkg.sv
package slc_pkg;
    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_t;
endpackage

// File: rtl/slc_scale.sv
module slc_scale #(
    parameter int CODE_W    = 12,
    parameter int SCALE_NUM = 13300,
    parameter int SCALE_SH  = 12,
    parameter int MID_MV    = 5500,
    parameter int DIFF_W    = 16
) (
    input  logic [CODE_W-1:0]        code,
    output logic signed [DIFF_W-1:0] diff
);
    localparam int PROD_W = CODE_W + $clog2(SCALE_NUM + 1);
    localparam int MV_W   = PROD_W - SCALE_SH;
    localparam logic [PROD_W-1:0] K   = PROD_W'(SCALE_NUM);
    localparam logic [DIFF_W-1:0] MID = DIFF_W'(MID_MV);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] shifted;
    logic [MV_W-1:0]   mv;

    always_comb begin
        prod    = {{(PROD_W-CODE_W){1'b0}}, code} * K;
        shifted = prod >> SCALE_SH;
        mv      = shifted[MV_W-1:0];
        diff    = $signed({{(DIFF_W-MV_W){1'b0}}, mv}) - $signed(MID);
    end
endmodule

// File: rtl/slc_cfg.sv
module slc_cfg #(
    parameter int BAND_W   = 16,
    parameter int CNT_W    = 16,
    parameter int BAND_DEF = 6000,
    parameter int PER_DEF  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_band,
    input  logic [BAND_W-1:0] wr_band_val,
    input  logic              wr_period,
    input  logic [CNT_W-1:0]  wr_period_val,
    output logic [BAND_W-1:0] band_q,
    output logic [CNT_W-1:0]  period_q
);
    localparam logic [BAND_W-1:0] BAND_RST = BAND_W'(BAND_DEF);
    localparam logic [CNT_W-1:0]  PER_RST  = CNT_W'(PER_DEF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            band_q   <= BAND_RST;
            period_q <= PER_RST;
        end else if (clr) begin
            band_q   <= BAND_RST;
            period_q <= PER_RST;
        end else begin
            if (wr_band)   band_q   <= wr_band_val;
            if (wr_period) period_q <= wr_period_val;
        end
    end
endmodule

// File: rtl/slc_level_fsm.sv
module slc_level_fsm
    import slc_pkg::*;
#(
    parameter int DIFF_W = 16,
    parameter int BAND_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stb,
    input  logic signed [DIFF_W-1:0] diff,
    input  logic [BAND_W-1:0]        band,
    output line_t                    level_q,
    output line_t                    level_nx,
    output logic                     changed
);
    localparam int CMP_W = ((DIFF_W > BAND_W) ? DIFF_W : BAND_W) + 1;

    logic signed [CMP_W-1:0] diff_x;
    logic signed [CMP_W-1:0] half_x;
    logic                    above;
    logic                    below;

    always_comb begin
        diff_x = $signed({{(CMP_W-DIFF_W){diff[DIFF_W-1]}}, diff});
        half_x = $signed({{(CMP_W-BAND_W+1){1'b0}}, band[BAND_W-1:1]});
        above  = diff_x > half_x;
        below  = diff_x < -half_x;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= LINE_LOW;
        else        level_q <= level_nx;
    end

    // next state and outputs
    always_comb begin
        level_nx = level_q;
        unique case (level_q)
            LINE_LOW:  if (stb && above) level_nx = LINE_HIGH; // RISE
            LINE_HIGH: if (stb && below) level_nx = LINE_LOW;  // FALL
            default:   level_nx = LINE_LOW;
        endcase
        changed = (level_nx != level_q);
    end
endmodule

// File: rtl/slc_phase.sv
module slc_phase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             changed,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] len_q,
    output logic [CNT_W-1:0] commit_q,
    output logic             emit
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] len_eff;
    logic [CNT_W-1:0] com_eff;
    logic [CNT_W:0]   len_inc;
    logic [CNT_W:0]   com_inc;
    logic [CNT_W-1:0] len_nx;
    logic [CNT_W-1:0] com_nx;

    always_comb begin
        len_eff = changed ? '0 : len_q;
        com_eff = changed ? (period >> 1) : commit_q;
        emit    = stb && (len_eff >= com_eff);
        len_inc = {1'b0, len_eff} + {{CNT_W{1'b0}}, 1'b1};
        com_inc = {1'b0, com_eff} + {1'b0, period};
        len_nx  = len_inc[CNT_W] ? CNT_MAX : len_inc[CNT_W-1:0];
        if (emit) com_nx = com_inc[CNT_W] ? CNT_MAX : com_inc[CNT_W-1:0];
        else      com_nx = com_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q    <= '0;
            commit_q <= '0;
        end else if (stb) begin
            len_q    <= len_nx;
            commit_q <= com_nx;
        end
    end
endmodule

// File: rtl/line_bit_recover.sv
module line_bit_recover
    import slc_pkg::*;
#(
    parameter int CODE_W    = 12,
    parameter int CNT_W     = 16,
    parameter int BAND_W    = 16,
    parameter int SCALE_NUM = 13300,
    parameter int SCALE_SH  = 12,
    parameter int MID_MV    = 5500,
    parameter int BAND_DEF  = 6000,
    parameter int PER_DEF   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_band,
    input  logic [BAND_W-1:0] wr_band_val,
    input  logic              wr_period,
    input  logic [CNT_W-1:0]  wr_period_val,
    input  logic              smp_stb,
    input  logic [CODE_W-1:0] smp_code,
    output logic              bit_vld,
    output logic              bit_out,
    output logic              dbg_level,
    output logic [CNT_W-1:0]  dbg_len,
    output logic [CNT_W-1:0]  dbg_commit
);
    localparam int PROD_W = CODE_W + $clog2(SCALE_NUM + 1);
    localparam int DIFF_W = PROD_W - SCALE_SH + 2;

    logic signed [DIFF_W-1:0] diff;
    logic [BAND_W-1:0]        band_q;
    logic [CNT_W-1:0]         period_q;
    line_t                    level_q;
    line_t                    level_nx;
    logic                     changed;
    logic                     emit;

    slc_scale #(
        .CODE_W(CODE_W), .SCALE_NUM(SCALE_NUM), .SCALE_SH(SCALE_SH),
        .MID_MV(MID_MV), .DIFF_W(DIFF_W)
    ) u_scale (
        .code(smp_code),
        .diff(diff)
    );

    slc_cfg #(
        .BAND_W(BAND_W), .CNT_W(CNT_W), .BAND_DEF(BAND_DEF), .PER_DEF(PER_DEF)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .wr_band(wr_band), .wr_band_val(wr_band_val),
        .wr_period(wr_period), .wr_period_val(wr_period_val),
        .band_q(band_q), .period_q(period_q)
    );

    slc_level_fsm #(
        .DIFF_W(DIFF_W), .BAND_W(BAND_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .stb(smp_stb), .diff(diff), .band(band_q),
        .level_q(level_q), .level_nx(level_nx), .changed(changed)
    );

    slc_phase #(
        .CNT_W(CNT_W)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .stb(smp_stb), .changed(changed),
        .period(period_q), .len_q(dbg_len), .commit_q(dbg_commit), .emit(emit)
    );

    always_comb begin
        bit_vld   = emit;
        bit_out   = (level_nx == LINE_HIGH);
        dbg_level = (level_q == LINE_HIGH);
    end
endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_stb,
    input logic             bit_vld,
    input logic             bit_out,
    input logic             dbg_level,
    input logic [CNT_W-1:0] dbg_len,
    input logic [CNT_W-1:0] dbg_commit
);
    logic flip;
    assign flip = smp_stb && (bit_out != dbg_level);

    a_r9_vld_needs_stb: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> smp_stb);

    a_r4_restart_len: assert property (@(posedge clk) disable iff (!rst_n)
        flip |=> dbg_len == 1);

    a_r6_len_step: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !flip && dbg_len != {CNT_W{1'b1}}) |=> dbg_len == $past(dbg_len) + 1'b1);

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> ($stable(dbg_len) && $stable(dbg_commit) && $stable(dbg_level)));

    a_r5_emit_point: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !flip) |-> dbg_len >= dbg_commit);

    a_r7_commit_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !flip) |=> dbg_commit >= $past(dbg_commit));

    a_r2_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> dbg_level == $past(bit_out));
endmodule

bind line_bit_recover slc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .bit_vld(bit_vld),
    .bit_out(bit_out), .dbg_level(dbg_level), .dbg_len(dbg_len),
    .dbg_commit(dbg_commit)
);

// File: tb/tb_line_bit_recover.sv
module tb_line_bit_recover;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        wr_band = 1'b0;
    logic [15:0] wr_band_val = '0;
    logic        wr_period = 1'b0;
    logic [15:0] wr_period_val = '0;
    logic        smp_stb = 1'b0;
    logic [11:0] smp_code = '0;
    logic        bit_vld, bit_out, dbg_level;
    logic [15:0] dbg_len, dbg_commit;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    int m_band = 6000;
    int m_per = 10;
    int m_level = 0;
    int m_len = 0;
    int m_commit = 0;

    line_bit_recover dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .wr_band(wr_band), .wr_band_val(wr_band_val),
        .wr_period(wr_period), .wr_period_val(wr_period_val),
        .smp_stb(smp_stb), .smp_code(smp_code),
        .bit_vld(bit_vld), .bit_out(bit_out), .dbg_level(dbg_level),
        .dbg_len(dbg_len), .dbg_commit(dbg_commit)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat16(input int x);
        return (x > 65535) ? 65535 : x;
    endfunction

    task automatic send(input int c);
        int mv, d, h, nl, ln, cm, em;
        @(negedge clk);
        smp_stb = 1'b1;
        smp_code = c[11:0];
        #1;
        mv = (c * 13300) >>> 12;
        d = mv - 5500;
        h = m_band / 2;
        nl = (d > h) ? 1 : ((d < -h) ? 0 : m_level);
        ln = (nl != m_level) ? 0 : m_len;
        cm = (nl != m_level) ? (m_per / 2) : m_commit;
        em = (ln >= cm) ? 1 : 0;
        check("R5 bit_vld", int'(bit_vld), em);
        check("R2/R3 bit_out level", int'(bit_out), nl);
        m_level = nl;
        m_commit = em ? sat16(cm + m_per) : cm;
        m_len = sat16(ln + 1);
        @(posedge clk);
        #1;
        smp_stb = 1'b0;
        check("R6 dbg_len", int'(dbg_len), m_len);
        check("R7 dbg_commit", int'(dbg_commit), m_commit);
        check("R4 dbg_level", int'(dbg_level), m_level);
    endtask

    task automatic write_cfg(input int band, input int per, input bit do_clr);
        @(negedge clk);
        clr = do_clr;
        wr_band = (band >= 0);
        wr_band_val = 16'(band);
        wr_period = (per >= 0);
        wr_period_val = 16'(per);
        @(posedge clk);
        #1;
        clr = 1'b0;
        wr_band = 1'b0;
        wr_period = 1'b0;
        if (do_clr) begin
            m_band = 6000;
            m_per = 10;
        end else begin
            if (band >= 0) m_band = band;
            if (per >= 0) m_per = per;
        end
    endtask

    initial begin
        int pers[4];
        pers = '{4, 7, 10, 3};
        #23;
        check("R1 dbg_len", int'(dbg_len), 0);
        check("R1 dbg_commit", int'(dbg_commit), 0);
        check("R1 dbg_level", int'(dbg_level), 0);
        check("R1 bit_vld", int'(bit_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // full code sweeps under the default width
        for (int c = 0; c < 4096; c++) send(c);
        for (int c = 4095; c >= 0; c--) send(c);

        // R9 and R6: idle cycles change nothing
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            #1;
            check("R9 no strobe no bit", int'(bit_vld), 0);
            check("R6 idle len", int'(dbg_len), m_len);
            check("R6 idle commit", int'(dbg_commit), m_commit);
        end

        // R4: square runs of many lengths for several periods
        foreach (pers[p]) begin
            write_cfg(-1, pers[p], 1'b0);
            for (int k = 1; k <= 24; k++) begin
                for (int j = 0; j < k; j++) send((k % 2) ? 4095 : 0);
            end
        end

        // R3: odd width, band edges both ways
        write_cfg(6001, -1, 1'b0);
        for (int c = 2580; c <= 2660; c++) send(c);
        for (int c = 1000; c >= 0; c--) send(c);
        write_cfg(0, -1, 1'b0);
        for (int c = 1600; c <= 1700; c++) send(c);
        for (int c = 1700; c >= 1600; c--) send(c);

        // R8: clr wins over simultaneous writes, defaults back
        @(negedge clk);
        clr = 1'b1;
        wr_band = 1'b1;
        wr_band_val = 16'd100;
        wr_period = 1'b1;
        wr_period_val = 16'd3;
        @(posedge clk);
        #1;
        clr = 1'b0;
        wr_band = 1'b0;
        wr_period = 1'b0;
        m_band = 6000;
        m_per = 10;
        send(0);
        for (int c = 2560; c <= 2700; c++) send(c);
        for (int j = 0; j < 30; j++) send(4095);
        send(0);
        check("R8 default half period", int'(dbg_commit), 5);

        // R7 and R6: saturation on a long steady run
        write_cfg(-1, 40000, 1'b0);
        send(4095);
        send(0);
        for (int j = 0; j < 66000; j++) send(0);
        check("R7 commit saturated", int'(dbg_commit), 65535);
        check("R6 len saturated", int'(dbg_len), 65535);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule